// File: doc/BRIEF.md
# DMA Channel Arm/Abort Control Register

This block holds the arm state of a five-channel DMA controller behind a byte-wide special-function-register port. A channel's arm bit enables it to move data; the data engine reads the per-channel `ch_armed` outputs and does nothing on a channel whose bit is low. Software arms or disarms channels by writing a byte whose low bits are the new arm pattern. The same port carries a cancel command. When the top bit of a written byte is set, every channel selected in the low bits of that byte is stopped. This applies whether the channel is mid-transfer or only waiting.

The engine reports back through two per-channel inputs. `cnt_done` pulses when a channel has moved its programmed count. `rpt_mode` says whether that channel runs in a repeating mode. A one-shot channel disarms itself at completion. A repeating channel stays armed. Each cancelled channel receives a single-cycle `ch_abort` strobe, which the engine uses to drop any transfer in flight.

Top module: `dma_arm_reg`

## Requirements
- R1: After synchronous reset, `ch_armed` is 0, `ch_abort` is 0 and `sfr_rdata` reads 0x00.
- R2: A write with bit 7 equal to 0 loads bits 4..0 of `sfr_wdata` into the arm bits of channels 4..0 at the next clock edge.
- R3: `sfr_rdata` always shows the arm bits in bits 4..0 and 0 in bits 7..5. Written values in bits 6..5 have no effect.
- R4: A write with bit 7 equal to 1 clears the arm bit of each channel whose bit in 4..0 is 1. The same edge raises `ch_abort` for exactly those channels, and `ch_abort` drops after one cycle unless the write repeats.
- R5: During a write with bit 7 equal to 1, channels whose select bit is 0 keep their arm bit. They are still subject to R6.
- R6: When `cnt_done` is high for an armed channel whose `rpt_mode` is 0, and no plain write targets it, that channel's arm bit clears at the next edge.
- R7: When `cnt_done` is high for an armed channel whose `rpt_mode` is 1, the arm bit stays set.
- R8: A plain write (bit 7 equal to 0) in the same cycle as a completion takes priority, so the channel takes the written bit.
- R9: A cancel write strobes `ch_abort` for a selected channel even if that channel was not armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Write byte: bit 7 is the cancel command, bits 4..0 are the channel pattern |
| sfr_rdata | output | 8 | Read byte: arm bits in 4..0, zero above |
| cnt_done | input | 5 | Per-channel transfer-count-reached pulse |
| rpt_mode | input | 5 | Per-channel repeating-mode flag |
| ch_armed | output | 5 | Per-channel arm state (transfer enable) |
| ch_abort | output | 5 | Per-channel one-cycle cancel strobe |

## Verification
Some rules are checked by assertions on every cycle:
- a strobed channel is never armed at the same time;
- a plain write lands its pattern in the arm bits one edge later;
- a one-shot completion disarms and a repeating completion does not, when no write interferes.

Other behaviour only the bench scenarios can show: that unselected channels survive a cancel write, that a write beats a same-cycle completion, that bits 6..5 are ignored, and that a strobe lasts a single cycle after an isolated cancel.

// File: rtl/dma_arm_pkg.sv
package dma_arm_pkg;

    localparam int unsigned NCH       = 5;
    localparam int unsigned SFR_W     = 8;
    localparam int unsigned CANCEL_IX = 7;

    // What happens to one channel's arm bit on the coming edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_KILL = 2'd2,
        ACT_DONE = 2'd3
    } arm_act_e;

    // Priority: plain write, then cancel, then one-shot completion
    function automatic arm_act_e pick_act(input logic load, input logic kill,
                                          input logic sel, input logic armed,
                                          input logic done, input logic rpt);
        if (load)                      return ACT_LOAD;
        else if (kill && sel)          return ACT_KILL;
        else if (armed && done && !rpt) return ACT_DONE;
        else                           return ACT_HOLD;
    endfunction

    function automatic logic next_arm(input arm_act_e act, input logic armed,
                                      input logic wbit);
        case (act)
            ACT_LOAD: return wbit;
            ACT_KILL: return 1'b0;
            ACT_DONE: return 1'b0;
            default:  return armed;
        endcase
    endfunction

endpackage

// File: rtl/dma_arm_wdec.sv
module dma_arm_wdec #(
    parameter int unsigned DW   = dma_arm_pkg::SFR_W,
    parameter int unsigned N    = dma_arm_pkg::NCH,
    parameter int unsigned CXIX = dma_arm_pkg::CANCEL_IX
) (
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic          load,
    output logic          kill,
    output logic [N-1:0]  sel
);
    always_comb begin
        load = we && !wdata[CXIX];
        kill = we &&  wdata[CXIX];
        sel  = wdata[N-1:0];
    end
endmodule

// File: rtl/dma_arm_cell.sv
module dma_arm_cell
    import dma_arm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic kill,
    input  logic sel,
    input  logic done,
    input  logic rpt,
    output logic armed,
    output logic abort_p
);
    arm_act_e act;

    always_comb act = pick_act(load, kill, sel, armed, done, rpt);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            abort_p <= 1'b0;
        end else begin
            armed   <= next_arm(act, armed, sel);
            abort_p <= (act == ACT_KILL);
        end
    end

    // R4
    strobe_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
        abort_p |-> !armed);

    // R6
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && done && !rpt && !load && !kill) |=> !armed);

    // R7
    repeat_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && done && rpt && !load && !(kill && sel)) |=> armed);

    // R9
    kill_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (kill && sel && !load) |=> abort_p);
endmodule

// File: rtl/dma_arm_reg.sv
module dma_arm_reg
    import dma_arm_pkg::*;
#(
    parameter int unsigned N    = NCH,
    parameter int unsigned DW   = SFR_W,
    parameter int unsigned CXIX = CANCEL_IX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sfr_we,
    input  logic [DW-1:0] sfr_wdata,
    output logic [DW-1:0] sfr_rdata,
    input  logic [N-1:0]  cnt_done,
    input  logic [N-1:0]  rpt_mode,
    output logic [N-1:0]  ch_armed,
    output logic [N-1:0]  ch_abort
);
    localparam int unsigned PADW = DW - N;

    logic         w_load;
    logic         w_kill;
    logic [N-1:0] w_sel;

    dma_arm_wdec #(.DW(DW), .N(N), .CXIX(CXIX)) u_wdec (
        .we    (sfr_we),
        .wdata (sfr_wdata),
        .load  (w_load),
        .kill  (w_kill),
        .sel   (w_sel)
    );

    for (genvar c = 0; c < N; c++) begin : g_ch
        dma_arm_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .load    (w_load),
            .kill    (w_kill),
            .sel     (w_sel[c]),
            .done    (cnt_done[c]),
            .rpt     (rpt_mode[c]),
            .armed   (ch_armed[c]),
            .abort_p (ch_abort[c])
        );
    end

    assign sfr_rdata = {{PADW{1'b0}}, ch_armed};

    // R2
    plain_load_chk: assert property (@(posedge clk) disable iff (rst)
        (sfr_we && !sfr_wdata[CXIX]) |=> (ch_armed == $past(sfr_wdata[N-1:0])));

    // R4
    strobe_only_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_abort != '0) |-> $past(sfr_we && sfr_wdata[CXIX]));
endmodule

// File: tb/tb_dma_arm_reg.sv
module tb_dma_arm_reg;
    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       sfr_we;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;
    logic [N-1:0] cnt_done, rpt_mode, ch_armed, ch_abort;

    always #5 clk = ~clk;

    dma_arm_reg dut (
        .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .cnt_done(cnt_done), .rpt_mode(rpt_mode),
        .ch_armed(ch_armed), .ch_abort(ch_abort)
    );

    typedef struct {
        logic [N-1:0] arm;
        logic [N-1:0] abt;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           total = 0;
    int           bad   = 0;
    logic [N-1:0] m_arm = '0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the post-edge expectation
    task automatic cyc(logic we, logic [7:0] wd, logic [N-1:0] dn,
                       logic [N-1:0] rp, string tag);
        exp_t e;
        @(negedge clk);
        sfr_we = we; sfr_wdata = wd; cnt_done = dn; rpt_mode = rp;
        e.abt = '0;
        for (int c = 0; c < N; c++) begin
            if (we && !wd[7])               e.arm[c] = wd[c];
            else if (we && wd[7] && wd[c]) begin e.arm[c] = 1'b0; e.abt[c] = 1'b1; end
            else if (m_arm[c] && dn[c] && !rp[c]) e.arm[c] = 1'b0;
            else                            e.arm[c] = m_arm[c];
        end
        m_arm = e.arm;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares after each edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " armed"}, 32'(ch_armed), 32'(e.arm));
            check({e.tag, " abort"}, 32'(ch_abort), 32'(e.abt));
            check({e.tag, " rdata"}, 32'(sfr_rdata), {27'd0, e.arm});
        end
    end

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; sfr_we = 0; sfr_wdata = '0; cnt_done = '0; rpt_mode = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 armed", 32'(ch_armed), 0);
        check("R1 abort", 32'(ch_abort), 0);
        check("R1 rdata", 32'(sfr_rdata), 0);
        rst = 1'b0;

        cyc(1, 8'h15, '0, '0, "R2 load 15");
        cyc(1, 8'h0A, '0, '0, "R2 load 0A");
        cyc(1, 8'h7F, '0, '0, "R3 ignore 6:5");
        cyc(0, 8'h00, '0, '0, "R3 idle");
        cyc(1, 8'h85, '0, '0, "R4 R5 abort 05");
        cyc(0, 8'h00, '0, '0, "R4 strobe drops");
        cyc(1, 8'h1F, '0, '0, "R2 rearm");
        cyc(0, 8'h00, 5'b00010, 5'b00000, "R6 oneshot done ch1");
        cyc(0, 8'h00, 5'b01000, 5'b01000, "R7 repeat done ch3");
        cyc(1, 8'h1D, 5'b11101, 5'b00000, "R8 write beats done");
        cyc(1, 8'h81, 5'b00100, 5'b00000, "R5 R6 abort ch0 done ch2");
        cyc(1, 8'h82, '0, '0, "R9 abort unarmed ch1");
        cyc(1, 8'h98, '0, '0, "R4 abort ch4 ch3");
        cyc(1, 8'h98, '0, '0, "R4 repeat abort");
        cyc(0, 8'h00, '0, '0, "R4 final idle");
        cyc(0, 8'h00, 5'b11111, 5'b00000, "R6 done on unarmed");
        repeat (3) @(posedge clk);
        #3;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule